// File: doc/BRIEF.md
# Float-to-Integer Truncating Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a normalised mantissa. The mantissa has a sticky bit beside it. The conversion always truncates toward zero, and no rounding-mode input exists.

Values whose integer part does not fit saturate to a sign-dependent limit. The same limit applies to infinities and NaNs. In every such case the invalid flag is raised and the inexact flag is suppressed. An in-range value that loses fraction bits raises inexact.

A result is requested by pulsing `in_valid` with the operand. The registered result and both flags appear together with `out_valid` one clock later.

Top module: `fti_convert`

## Requirements
- R1: Class code 0 (zero) gives a result of 0 with inexact and invalid both clear, whatever the sign, exponent and mantissa.
- R2: For class code 1 (number) with exponent e in 0..31, mantissa bit 65 carries weight 2^e and each lower bit carries half the weight of the bit above it. The magnitude is the sum of the mantissa bits of weight 1 or more.
- R3: For an in-range number, inexact is set exactly when a mantissa bit of weight below 1 is set, or when the sticky input is set.
- R4: A number with a negative exponent gives magnitude 0. Its inexact flag is set when any mantissa bit or the sticky bit is set.
- R5: A non-overflowing number with sign 1 yields the two's-complement negation of its magnitude, and with sign 0 the magnitude itself.
- R6: A number with an exponent of 32 or more overflows.
- R7: A number whose magnitude is at least 2^31 + sign overflows. As a result, 0x80000000 is produced without overflow only for a negative input.
- R8: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) always overflow. The unused codes 5 to 7 also overflow.
- R9: On overflow the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1, invalid is set and inexact is clear.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Result and flags update only on an accepted operand and hold otherwise.
- R11: During and after reset, `out_valid`, the result and both flags are 0 until the first accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W (12) | Signed unbiased exponent |
| in_mant | input | MANT_W (66) | Mantissa, leading 1 at the top bit, two lowest bits guard and round |
| in_sticky | input | 1 | OR of all bits below the guard and round bits |
| out_valid | output | 1 | Result valid |
| out_result | output | OUT_W (32) | Two's-complement integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The bench builds the block at its default parameters: a 66-bit mantissa, a 32-bit result and a 12-bit exponent. With these values the exponent can be driven far past both ends of the shift window, for example -100 and 1000. The result width also places the asymmetric limit at 2^31, which lets the bench check both sides of that boundary for each sign. A bit-by-bit weighting model in the bench, written independently of the barrel-shift formulation in the RTL, supplies the expected values.

// File: rtl/fti_pkg.sv
package fti_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fti_class_e;

  // Saturated value for an overflowing conversion: max positive plus sign.
  function automatic logic [31:0] sat_word(input logic neg);
    return {1'b0, {31{1'b1}}} + {31'd0, neg};
  endfunction

  // Signed two's-complement application of a sign to a magnitude.
  function automatic logic [31:0] apply_sign(input logic [31:0] mag, input logic neg);
    return neg ? (~mag + 32'd1) : mag;
  endfunction
endpackage

// File: rtl/fti_align.sv
module fti_align #(
  parameter int MANT_W = 66,
  parameter int OUT_W  = 32,
  parameter int EXP_W  = 12
) (
  input  logic [MANT_W-1:0]       mant,
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic                    sticky,
  output logic [OUT_W-1:0]        mag,
  output logic                    lost
);
  localparam int SH_W = $clog2(MANT_W + 1);

  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] lost_mask;

  always_comb begin
    sh        = '0;
    lost_mask = '0;
    mag       = '0;
    lost      = sticky;
    if (exp_in < 0) begin
      // Whole mantissa lies below the binary point.
      lost = (|mant) | sticky;
    end else if (exp_in < OUT_W) begin
      sh        = SH_W'(MANT_W - 1) - SH_W'(exp_in);
      mag       = OUT_W'(mant >> sh);
      lost_mask = ~({MANT_W{1'b1}} << sh);
      lost      = (|(mant & lost_mask)) | sticky;
    end
  end
endmodule

// File: rtl/fti_range.sv
module fti_range #(
  parameter int OUT_W = 32
) (
  input  logic [OUT_W-1:0] mag,
  input  logic             neg,
  output logic             range_ovf,
  output logic [OUT_W-1:0] value
);
  localparam logic [OUT_W:0] HALF = {2'b01, {(OUT_W-1){1'b0}}};

  logic [OUT_W:0] limit;

  always_comb begin
    limit     = HALF + {{OUT_W{1'b0}}, neg};
    range_ovf = ({1'b0, mag} >= limit);
    value     = neg ? (~mag + {{(OUT_W-1){1'b0}}, 1'b1}) : mag;
  end
endmodule

// File: rtl/fti_convert.sv
module fti_convert #(
  parameter int MANT_W = 66,
  parameter int OUT_W  = 32,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_class,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_result,
  output logic                    out_inexact,
  output logic                    out_invalid
);
  import fti_pkg::*;

  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  fti_class_e     cls;
  logic           is_zero, is_num, exp_big, range_ovf, do_ovf;
  logic [OUT_W-1:0] mag, signed_val, sat_val, nxt_result;
  logic           lost, nxt_inexact;

  assign cls     = fti_class_e'(in_class);
  assign is_zero = (cls == CLS_ZERO);
  assign is_num  = (cls == CLS_NUM);
  assign exp_big = (in_exp >= OUT_W);

  fti_align #(.MANT_W(MANT_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_align (
    .mant(in_mant), .exp_in(in_exp), .sticky(in_sticky), .mag(mag), .lost(lost)
  );

  fti_range #(.OUT_W(OUT_W)) u_range (
    .mag(mag), .neg(in_sign), .range_ovf(range_ovf), .value(signed_val)
  );

  assign do_ovf  = !is_zero && (!is_num || exp_big || range_ovf);
  assign sat_val = POS_MAX + {{(OUT_W-1){1'b0}}, in_sign};

  always_comb begin
    if (is_zero) begin
      nxt_result  = '0;
      nxt_inexact = 1'b0;
    end else if (do_ovf) begin
      nxt_result  = sat_val;
      nxt_inexact = 1'b0;
    end else begin
      nxt_result  = signed_val;
      nxt_inexact = lost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_inexact <= nxt_inexact;
        out_invalid <= do_ovf;
      end
    end
  end
endmodule

// File: rtl/fti_checker.sv
module fti_checker #(
  parameter int MANT_W = 66,
  parameter int OUT_W  = 32,
  parameter int EXP_W  = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              in_class,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [MANT_W-1:0]       in_mant,
  input logic                    in_sticky,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_result,
  input logic                    out_inexact,
  input logic                    out_invalid
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));
  assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd0) |=> (out_result == '0 && !out_inexact && !out_invalid));
  assert_nonnum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class >= 3'd2) |=> out_invalid);
  assert_bigexp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd1 && in_exp >= OUT_W) |=> out_invalid);
  assert_sat_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (!out_inexact && (out_result == POS_MAX || out_result == NEG_MAX)));
  assert_neg_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd1 && in_exp < 0) |=> (out_result == '0 && !out_invalid));
endmodule

bind fti_convert fti_checker #(.MANT_W(MANT_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
  .out_valid(out_valid), .out_result(out_result),
  .out_inexact(out_inexact), .out_invalid(out_invalid)
);

// File: tb/sim_fti_convert.sv
`timescale 1ns/1ps
module sim_fti_convert;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [2:0]         in_class = 3'd0;
  logic               in_sign = 1'b0;
  logic signed [11:0] in_exp = '0;
  logic [65:0]        in_mant = '0;
  logic               in_sticky = 1'b0;
  logic               out_valid, out_inexact, out_invalid;
  logic [31:0]        out_result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fti_convert u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  localparam logic [65:0] ONE = {1'b1, 65'd0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Independent model: each mantissa bit weighed by its power of two.
  task automatic model(input logic [2:0] c, input logic s, input int e, input logic [65:0] m,
                       input logic st, output logic [31:0] r, output logic inx, output logic inv);
    logic [32:0] acc;
    logic frac;
    logic ovf;
    acc = '0; frac = st; ovf = 1'b0;
    if (c == 3'd0) begin
      r = '0; inx = 1'b0; inv = 1'b0;
      return;
    end
    if (c != 3'd1 || e >= 32) ovf = 1'b1;
    else begin
      for (int i = 0; i < 66; i++) begin
        if (e - i >= 0) begin
          if (m[65-i]) acc = acc + (33'd1 << (e - i));
        end else frac = frac | m[65-i];
      end
      if (acc > (s ? 33'h080000000 : 33'h07FFFFFFF)) ovf = 1'b1;
    end
    if (ovf) begin
      r = s ? 32'h80000000 : 32'h7FFFFFFF; inx = 1'b0; inv = 1'b1;
    end else begin
      r = s ? (32'd0 - acc[31:0]) : acc[31:0]; inx = frac; inv = 1'b0;
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic s, input int e,
                       input logic [65:0] m, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 12'(e);
    in_mant = m; in_sticky = st;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string req, input logic [2:0] c, input logic s, input int e,
                     input logic [65:0] m, input logic st, input logic [31:0] lit_r,
                     input logic lit_inx, input logic lit_inv);
    logic [31:0] r;
    logic inx, inv;
    model(c, s, e, m, st, r, inx, inv);
    apply(c, s, e, m, st);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, out_result, r);
    check({req, " inexact"}, {31'd0, out_inexact}, {31'd0, inx});
    check({req, " invalid"}, {31'd0, out_invalid}, {31'd0, inv});
    check({req, " literal"}, {out_result[29:0], out_inexact, out_invalid} ^ 32'd0,
          {lit_r[29:0], lit_inx, lit_inv});
    check({req, " literal msb"}, {30'd0, lit_r[31:30]}, {30'd0, out_result[31:30]});
  endtask

  task automatic t_reset;
    check("R11 valid", {31'd0, out_valid}, 32'd0);
    check("R11 result", out_result, 32'd0);
    check("R11 flags", {30'd0, out_inexact, out_invalid}, 32'd0);
  endtask

  task automatic t_zero;
    run("R1 zero", 3'd0, 1'b1, 20, '1, 1'b1, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_number;
    run("R2 one", 3'd1, 1'b0, 0, ONE, 1'b0, 32'd1, 1'b0, 1'b0);
    run("R2 big", 3'd1, 1'b0, 20, ONE | (ONE >> 20), 1'b0, 32'h00100001, 1'b0, 1'b0);
    run("R3 frac", 3'd1, 1'b0, 0, ONE | (ONE >> 1), 1'b0, 32'd1, 1'b1, 1'b0);
    run("R3 sticky", 3'd1, 1'b0, 3, ONE, 1'b1, 32'd8, 1'b1, 1'b0);
    run("R3 guard", 3'd1, 1'b0, 2, ONE | 66'd1, 1'b0, 32'd4, 1'b1, 1'b0);
    run("R3 max", 3'd1, 1'b0, 30, '1, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_negexp;
    run("R4 half", 3'd1, 1'b0, -1, ONE, 1'b0, 32'd0, 1'b1, 1'b0);
    run("R4 tiny", 3'd1, 1'b1, -100, ONE, 1'b0, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic t_sign;
    run("R5 neg", 3'd1, 1'b1, 1, ONE | (ONE >> 2), 1'b0, 32'hFFFFFFFE, 1'b1, 1'b0);
    run("R5 neg7", 3'd1, 1'b1, 2, ONE | (ONE >> 1) | (ONE >> 2), 1'b0, 32'hFFFFFFF9, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;
    run("R6 exp32", 3'd1, 1'b0, 32, ONE, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1);
    run("R6 exp1000", 3'd1, 1'b1, 1000, ONE, 1'b1, 32'h80000000, 1'b0, 1'b1);
    run("R7 pos2p31", 3'd1, 1'b0, 31, ONE | 66'd3, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1);
    run("R7 neg2p31", 3'd1, 1'b1, 31, ONE, 1'b0, 32'h80000000, 1'b0, 1'b0);
    run("R7 neg_over", 3'd1, 1'b1, 31, ONE | (ONE >> 1), 1'b0, 32'h80000000, 1'b0, 1'b1);
    run("R8 inf", 3'd2, 1'b0, 0, ONE, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1);
    run("R8 qnan", 3'd3, 1'b1, 0, ONE, 1'b0, 32'h80000000, 1'b0, 1'b1);
    run("R8 snan", 3'd4, 1'b0, 5, ONE, 1'b1, 32'h7FFFFFFF, 1'b0, 1'b1);
    run("R9 unused", 3'd6, 1'b1, 0, ONE, 1'b0, 32'h80000000, 1'b0, 1'b1);
  endtask

  task automatic t_timing;
    // Back-to-back operands, then an idle cycle that must hold the result.
    @(negedge clk);
    in_valid = 1'b1; in_class = 3'd1; in_sign = 1'b0; in_exp = 12'd4; in_mant = ONE; in_sticky = 1'b0;
    @(negedge clk);
    check("R10 first", out_result, 32'd16);
    in_exp = 12'd5;
    @(negedge clk);
    check("R10 second", out_result, 32'd32);
    in_valid = 1'b0; in_exp = 12'd7; in_sign = 1'b1;
    @(negedge clk);
    check("R10 idle valid", {31'd0, out_valid}, 32'd0);
    check("R10 hold", out_result, 32'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_number();
    t_negexp();
    t_sign();
    t_overflow();
    t_timing();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule